// File: doc/BRIEF.md
# CAN Retransmission Attempt Limiter

This block sits beside the transmit scheduler of a CAN controller and keeps, for every transmit FIFO, a count of how many times the frame at the head of that FIFO has been put on the bus. The scheduler reports each start of an attempt and each completion, with a status code. When an attempt fails, the block decides whether the frame goes back into the queue or is dropped.

Three kinds of failure lead to an automatic resend: lost arbitration, no acknowledge, and a bus error. A global enable decides whether each FIFO's 2-bit attempt field is obeyed. With the enable clear, the field has no effect and resends never stop. With the enable set, a FIFO whose attempts are used up gets an abandon pulse instead of a retry pulse. Its sticky exhausted bit is also set, and it stays set until the next frame is loaded into that FIFO.

Top module: `can_retry_limiter`

## Requirements
- R1: After reset every attempt count is 0, every exhausted bit is 0, and no retry or abandon pulse is present.
- R2: A start strobe for FIFO n raises count n by one on the next clock edge.
- R3: The completion status is encoded as 00 = success, 01 = lost arbitration, 10 = no acknowledge, 11 = bus error. Codes 01, 10 and 11 are failures.
- R4: A failure on FIFO n with the limit not reached gives a one-cycle retry pulse on bit n of retry_o, one cycle after the completion. The count does not change.
- R5: The per-FIFO attempt field is decoded as follows: 00 allows one attempt, 01 allows three attempts, and 10 or 11 is unlimited.
- R6: When the global limit enable is 0, the attempt field is ignored. Every failure gives a retry and never an abandon.
- R7: When the limit is active and the count is at or above the allowed number, a failure gives a one-cycle abandon pulse on bit n of abandon_o and no retry. Bit n of exhausted_o is then set and stays set.
- R8: A successful completion clears the count. It gives neither a retry pulse nor an abandon pulse.
- R9: A frame load on FIFO n clears count n and exhausted bit n. A load takes precedence over any other event on the same FIFO in the same cycle.
- R10: Events on one FIFO leave the count and exhausted bit of every other FIFO unchanged.
- R11: The count saturates at its maximum value (15 by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| limit_en_i | input | 1 | Global enable for the per-FIFO attempt limit |
| attempt_cfg_i | input | 2*NUM_FIFO | Attempt field for each FIFO, 2 bits per FIFO |
| load_i | input | 1 | New frame loaded |
| load_fifo_i | input | FIFO_W | FIFO index for the load |
| start_i | input | 1 | Start of a transmission attempt |
| start_fifo_i | input | FIFO_W | FIFO index for the start |
| done_i | input | 1 | Attempt completed |
| done_fifo_i | input | FIFO_W | FIFO index for the completion |
| done_status_i | input | 2 | Completion status code |
| retry_o | output | NUM_FIFO | One-cycle retry request for each FIFO |
| abandon_o | output | NUM_FIFO | One-cycle abandon flag for each FIFO |
| exhausted_o | output | NUM_FIFO | Sticky attempts-exhausted status for each FIFO |
| attempt_cnt_o | output | CNT_W*NUM_FIFO | Attempt count for each FIFO |

## Verification
The hardest point to reach is the exact boundary where a failure turns from a retry into an abandon. Reaching it takes a chain of alternating start strobes and failures, and the chain has a different length for each attempt field and each enable setting. The bench sweeps both enable values, all four field codes and all three failure codes. For each combination it runs start/fail pairs until an abandon appears or five attempts are done, predicting each outcome from the decoded limit. Saturation needs sixteen or more starts with no success in between, so it is driven by a separate long run on an unlimited FIFO.

// File: rtl/can_retry_pkg.sv
package can_retry_pkg;
  typedef enum logic [1:0] {
    ST_OK       = 2'b00,
    ST_ARB_LOST = 2'b01,
    ST_NO_ACK   = 2'b10,
    ST_BUS_ERR  = 2'b11
  } done_status_e;

  localparam logic [1:0] CFG_ONE   = 2'b00;
  localparam logic [1:0] CFG_THREE = 2'b01;
endpackage

// File: rtl/can_retry_limit_dec.sv
module can_retry_limit_dec
  import can_retry_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             limit_en_i,
  input  logic [1:0]       cfg_i,
  output logic             limited_o,
  output logic [CNT_W-1:0] limit_o
);
  always_comb begin
    limited_o = 1'b0;
    limit_o   = '0;
    if (limit_en_i) begin
      unique case (cfg_i)
        CFG_ONE:   begin limited_o = 1'b1; limit_o = CNT_W'(1); end
        CFG_THREE: begin limited_o = 1'b1; limit_o = CNT_W'(3); end
        default:   begin limited_o = 1'b0; limit_o = '0;        end
      endcase
    end
  end
endmodule

// File: rtl/can_retry_slot.sv
module can_retry_slot
  import can_retry_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             limit_en_i,
  input  logic [1:0]       cfg_i,
  input  logic             load_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [1:0]       status_i,
  output logic             retry_o,
  output logic             abandon_o,
  output logic             exhausted_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             limited;
  logic [CNT_W-1:0] limit;
  logic             ok_done, fail_done, reached;

  can_retry_limit_dec #(.CNT_W(CNT_W)) u_dec (
    .limit_en_i (limit_en_i),
    .cfg_i      (cfg_i),
    .limited_o  (limited),
    .limit_o    (limit)
  );

  assign ok_done   = done_i && (status_i == ST_OK);
  assign fail_done = done_i && (status_i != ST_OK) && !load_i;
  assign reached   = limited && (cnt_o >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o       <= '0;
      exhausted_o <= 1'b0;
      retry_o     <= 1'b0;
      abandon_o   <= 1'b0;
    end else begin
      retry_o   <= fail_done && !reached;
      abandon_o <= fail_done && reached;
      if (load_i) begin
        cnt_o       <= '0;
        exhausted_o <= 1'b0;
      end else begin
        if (ok_done)                          cnt_o <= '0;
        else if (start_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
        if (fail_done && reached)             exhausted_o <= 1'b1;
      end
    end
  end

  a_r7_abandon_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(retry_o && abandon_o));
  a_r7_abandon_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abandon_o |-> exhausted_o);
  a_r8_success_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && status_i == ST_OK) |=> (!retry_o && !abandon_o));
  a_r6_unlimited_retry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && status_i != ST_OK && !limit_en_i && !load_i) |=> retry_o);
  a_r9_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == '0 && !exhausted_o));
  a_r11_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !load_i && !(done_i && status_i == ST_OK)) |=> cnt_o == CNT_MAX);
endmodule

// File: rtl/can_retry_limiter.sv
module can_retry_limiter
  import can_retry_pkg::*;
#(
  parameter int NUM_FIFO = 4,
  parameter int CNT_W    = 4,
  localparam int FIFO_W  = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      limit_en_i,
  input  logic [2*NUM_FIFO-1:0]     attempt_cfg_i,
  input  logic                      load_i,
  input  logic [FIFO_W-1:0]         load_fifo_i,
  input  logic                      start_i,
  input  logic [FIFO_W-1:0]         start_fifo_i,
  input  logic                      done_i,
  input  logic [FIFO_W-1:0]         done_fifo_i,
  input  logic [1:0]                done_status_i,
  output logic [NUM_FIFO-1:0]       retry_o,
  output logic [NUM_FIFO-1:0]       abandon_o,
  output logic [NUM_FIFO-1:0]       exhausted_o,
  output logic [CNT_W*NUM_FIFO-1:0] attempt_cnt_o
);
  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_slot
    logic sel_load, sel_start, sel_done;
    assign sel_load  = load_i  && (load_fifo_i  == FIFO_W'(g));
    assign sel_start = start_i && (start_fifo_i == FIFO_W'(g));
    assign sel_done  = done_i  && (done_fifo_i  == FIFO_W'(g));

    can_retry_slot #(.CNT_W(CNT_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .limit_en_i  (limit_en_i),
      .cfg_i       (attempt_cfg_i[2*g +: 2]),
      .load_i      (sel_load),
      .start_i     (sel_start),
      .done_i      (sel_done),
      .status_i    (done_status_i),
      .retry_o     (retry_o[g]),
      .abandon_o   (abandon_o[g]),
      .exhausted_o (exhausted_o[g]),
      .cnt_o       (attempt_cnt_o[CNT_W*g +: CNT_W])
    );
  end

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(retry_o | abandon_o));
endmodule

// File: tb/can_retry_limiter_bench.sv
module can_retry_limiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int CW = 4;
  localparam int FW = 2;

  logic clk = 0, rst_n = 0;
  logic limit_en = 0;
  logic [2*NF-1:0] cfg = '0;
  logic load = 0, start = 0, done = 0;
  logic [FW-1:0] load_f = '0, start_f = '0, done_f = '0;
  logic [1:0] status = '0;
  logic [NF-1:0] retry, abandon, exh;
  logic [CW*NF-1:0] cnt;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_retry_limiter #(.NUM_FIFO(NF), .CNT_W(CW)) u_can_retry_limiter (
    .clk_i(clk), .rst_ni(rst_n), .limit_en_i(limit_en), .attempt_cfg_i(cfg),
    .load_i(load), .load_fifo_i(load_f), .start_i(start), .start_fifo_i(start_f),
    .done_i(done), .done_fifo_i(done_f), .done_status_i(status),
    .retry_o(retry), .abandon_o(abandon), .exhausted_o(exh), .attempt_cnt_o(cnt));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cnt_of(int f);
    return int'(cnt[CW*f +: CW]);
  endfunction

  task automatic do_load(int f);
    @(negedge clk); load = 1; load_f = FW'(f);
    @(negedge clk); load = 0;
  endtask

  task automatic do_start(int f);
    @(negedge clk); start = 1; start_f = FW'(f);
    @(negedge clk); start = 0;
  endtask

  task automatic do_done(int f, int st);
    @(negedge clk); done = 1; done_f = FW'(f); status = 2'(st);
    @(negedge clk); done = 0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cnt", int'(cnt), 0);
    chk("R1 exhausted", int'(exh), 0);
    chk("R1 pulses", int'(retry | abandon), 0);
    rst_n = 1;
    @(negedge clk);

    // R3 R4 R5 R6 R7 sweep
    for (int en = 0; en < 2; en++) begin
      for (int c = 0; c < 4; c++) begin
        for (int st = 1; st < 4; st++) begin
          int lim;
          bit gone;
          limit_en = en[0];
          cfg = '0;
          cfg[2*c +: 2] = 2'(c);
          lim = (en == 0 || c >= 2) ? 1000 : (c == 0 ? 1 : 3);
          for (int f = 0; f < NF; f++) do_load(f);
          chk("R9 exhausted cleared", int'(exh), 0);
          gone = 0;
          for (int n = 1; n <= 5 && !gone; n++) begin
            do_start(c);
            chk("R2 count", cnt_of(c), n);
            do_done(c, st);
            if (n >= lim) begin
              chk("R7 abandon", int'(abandon), 1 << c);
              chk("R7 no retry", int'(retry), 0);
              chk("R7 exhausted", int'(exh), 1 << c);
              gone = 1;
            end else begin
              chk("R4 retry", int'(retry), 1 << c);
              chk(en == 0 ? "R6 no abandon" : "R5 no abandon", int'(abandon), 0);
              chk("R4 count unchanged", cnt_of(c), n);
            end
            for (int o = 0; o < NF; o++)
              if (o != c) chk("R10 other count", cnt_of(o), 0);
          end
          @(negedge clk);
          chk("R7 sticky", int'(exh), gone ? (1 << c) : 0);
          chk("R7 pulse ends", int'(abandon | retry), 0);
        end
      end
    end

    // R8 success clears, R3 status 00 is success
    limit_en = 1; cfg = '0;
    do_load(1);
    do_start(1);
    do_done(1, 0);
    chk("R8 no pulse", int'(retry | abandon), 0);
    chk("R8 count cleared", cnt_of(1), 0);

    // R9 load clears exhausted
    do_start(1);
    do_done(1, 2);
    chk("R7 abandon f1", int'(abandon), 2);
    do_load(1);
    chk("R9 exhausted", int'(exh), 0);
    chk("R9 count", cnt_of(1), 0);

    // R9 load beats failure same cycle
    do_start(1);
    @(negedge clk); load = 1; load_f = 1; done = 1; done_f = 1; status = 2'b11;
    @(negedge clk); load = 0; done = 0;
    chk("R9 load wins pulse", int'(retry | abandon), 0);
    chk("R9 load wins count", cnt_of(1), 0);

    // R11 saturation, unlimited FIFO
    cfg = 8'b1100_0000;
    do_load(3);
    for (int i = 0; i < 20; i++) do_start(3);
    chk("R11 saturate", cnt_of(3), 15);
    do_done(3, 1);
    chk("R11 retry at max", int'(retry), 8);
    chk("R10 others", cnt_of(0) + cnt_of(2), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule